// File: doc/BRIEF.md
# Tri-Port Latched Bus Exchanger

The exchanger connects a host-side data port (A) with two memory-side ports (P1 for the even bank, P2 for the odd bank). It is used for even/odd memory interleaving and for address multiplexing. There are four storage paths, each with its own enable: A to P1, A to P2, P1 to A and P2 to A. A return select decides which of the two return paths drives port A. Each port has its own active-low drive enable.

All storage is modelled as synchronous latches inside one clock domain. While an enable is high, the path is transparent and the output follows the inbound data in the same cycle. The path stores the inbound value at every rising clock edge where the enable is high. While the enable is low, the output shows the value stored at the last such edge. The latch storage has no reset.

Each bidirectional pad is split into an external level, a per-bit external-drive flag, the block's driven value, its drive enable and the resolved pad level. Every data pin has a keeper. The keeper follows the resolved level while something drives the pin. It holds that level while nobody drives the pin. A reset clears it to zero.

Top module: `tri_port_exchanger`

## Requirements
- R1: While `fwd_le1` (or `fwd_le2`) is high, `p1_out` (or `p2_out`) equals port A's inbound data in the same cycle. The inbound data is `a_in` on bits where `a_ext` is 1.
- R2: After a rising edge with a forward enable high, the output holds the value captured at the last such edge for as long as the enable stays low, whatever happens on `a_in`.
- R3: Both forward paths take their data from port A, so one A value can be loaded into P1, P2 or both.
- R4: `ret_le1` and `ret_le2` control the P1-to-A and P2-to-A paths respectively, with the same transparent and hold behaviour as R1 and R2.
- R5: `a_out` carries the P1 return path when `ret_sel` is 1 and the P2 return path when `ret_sel` is 0.
- R6: When a port's `*_oe_n` is 0, its `*_oe` is all ones and its `*_pad` equals its `*_out`. When `*_oe_n` is 1, its `*_oe` is all zeros.
- R7: The P1 and P2 drive enables are independent. One B port can drive its stored data while the other port's external value passes through to A.
- R8: A pad bit that neither the block nor the external side drives keeps the last driven level on `*_pad`. On such bits the inbound data is that kept level.
- R9: After reset, with nothing driving, every pad reads zero and every `*_oe` is zero.
- R10: When both the block and the external side drive a pin, the pad shows the block's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset for the keepers |
| fwd_le1 | input | 1 | A-to-P1 latch enable |
| fwd_le2 | input | 1 | A-to-P2 latch enable |
| ret_le1 | input | 1 | P1-to-A latch enable |
| ret_le2 | input | 1 | P2-to-A latch enable |
| ret_sel | input | 1 | 1 selects the P1 return path, 0 selects the P2 return path |
| a_oe_n | input | 1 | port A drive enable, active low |
| p1_oe_n | input | 1 | port P1 drive enable, active low |
| p2_oe_n | input | 1 | port P2 drive enable, active low |
| a_in | input | 12 | external level on port A |
| a_ext | input | 12 | per-bit external drive flag, port A |
| a_out | output | 12 | value the block drives on port A |
| a_oe | output | 12 | per-bit drive enable, port A |
| a_pad | output | 12 | resolved level on port A |
| p1_in | input | 12 | external level on port P1 |
| p1_ext | input | 12 | per-bit external drive flag, port P1 |
| p1_out | output | 12 | value the block drives on port P1 |
| p1_oe | output | 12 | per-bit drive enable, port P1 |
| p1_pad | output | 12 | resolved level on port P1 |
| p2_in | input | 12 | external level on port P2 |
| p2_ext | input | 12 | per-bit external drive flag, port P2 |
| p2_out | output | 12 | value the block drives on port P2 |
| p2_oe | output | 12 | per-bit drive enable, port P2 |
| p2_pad | output | 12 | resolved level on port P2 |

## Verification
The hardest situation to reach is a floating pin whose kept level then feeds a transparent return path. To get there, a value must first be driven onto P2 and captured. The external drive is then removed with the port's own driver off. Only after that is the return latch opened, so that port A must show the kept level.

A second hard case is a forward latch that is closed while its sibling stays open. The stimulus changes A with one enable low and the other high, which shows hold and transparency side by side. Randomised cycles with per-bit external drive then cover mixed driven and floating bits.

// File: rtl/exch_pkg.sv
package exch_pkg;
  localparam int unsigned NUM_PORTS = 3;
  localparam int unsigned PORT_A    = 0;
  localparam int unsigned PORT_1    = 1;
  localparam int unsigned PORT_2    = 2;
  localparam int unsigned NUM_PATHS = 2;

  typedef enum logic {
    RET_FROM_P2 = 1'b0,
    RET_FROM_P1 = 1'b1
  } ret_sel_e;
endpackage

// File: rtl/exch_latch.sv
module exch_latch #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held_q;
  logic [W-1:0] held_nxt;

  always_comb begin
    held_nxt = held_q;
    if (le) held_nxt = d;
  end

  always_ff @(posedge clk) begin
    held_q <= held_nxt;
  end

  assign q = le ? d : held_q;
endmodule

// File: rtl/exch_pad.sv
module exch_pad #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         drv_en,
  input  logic [W-1:0] drv_val,
  input  logic [W-1:0] ext_en,
  input  logic [W-1:0] ext_val,
  output logic [W-1:0] pad,
  output logic [W-1:0] inbound
);
  logic [W-1:0] keep_q;
  logic [W-1:0] keep_nxt;
  logic [W-1:0] driven;
  logic [W-1:0] own_mask;

  assign own_mask = {W{drv_en}};
  assign driven   = own_mask | ext_en;

  always_comb begin
    pad      = (own_mask & drv_val) | (~own_mask & ext_en & ext_val) | (~driven & keep_q);
    inbound  = (ext_en & ext_val) | (~ext_en & keep_q);
    keep_nxt = (driven & pad) | (~driven & keep_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) keep_q <= '0;
    else        keep_q <= keep_nxt;
  end
endmodule

// File: rtl/tri_port_exchanger.sv
module tri_port_exchanger
  import exch_pkg::*;
#(
  parameter int unsigned W           = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fwd_le1,
  input  logic         fwd_le2,
  input  logic         ret_le1,
  input  logic         ret_le2,
  input  logic         ret_sel,
  input  logic         a_oe_n,
  input  logic         p1_oe_n,
  input  logic         p2_oe_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] a_ext,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] a_pad,
  input  logic [W-1:0] p1_in,
  input  logic [W-1:0] p1_ext,
  output logic [W-1:0] p1_out,
  output logic [W-1:0] p1_oe,
  output logic [W-1:0] p1_pad,
  input  logic [W-1:0] p2_in,
  input  logic [W-1:0] p2_ext,
  output logic [W-1:0] p2_out,
  output logic [W-1:0] p2_oe,
  output logic [W-1:0] p2_pad
);
  localparam int unsigned SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] rst_sync_q;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_MSB-1:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_MSB];

  logic [NUM_PORTS-1:0][W-1:0] pin_lvl;
  logic [NUM_PORTS-1:0][W-1:0] pin_ext;
  logic [NUM_PORTS-1:0][W-1:0] drv_val;
  logic [NUM_PORTS-1:0][W-1:0] pad_lvl;
  logic [NUM_PORTS-1:0][W-1:0] inb;
  logic [NUM_PORTS-1:0]        drv_en;

  logic [NUM_PATHS-1:0]        fwd_le;
  logic [NUM_PATHS-1:0]        ret_le;
  logic [NUM_PATHS-1:0][W-1:0] fwd_q;
  logic [NUM_PATHS-1:0][W-1:0] ret_q;
  ret_sel_e                    sel_e;

  always_comb begin
    pin_lvl[PORT_A] = a_in;
    pin_lvl[PORT_1] = p1_in;
    pin_lvl[PORT_2] = p2_in;
    pin_ext[PORT_A] = a_ext;
    pin_ext[PORT_1] = p1_ext;
    pin_ext[PORT_2] = p2_ext;
    drv_en[PORT_A]  = ~a_oe_n;
    drv_en[PORT_1]  = ~p1_oe_n;
    drv_en[PORT_2]  = ~p2_oe_n;
  end

  assign fwd_le = {fwd_le2, fwd_le1};
  assign ret_le = {ret_le2, ret_le1};
  assign sel_e  = ret_sel_e'(ret_sel);

  for (genvar k = 0; k < NUM_PATHS; k++) begin : g_path
    exch_latch #(.W(W)) u_fwd (
      .clk (clk),
      .le  (fwd_le[k]),
      .d   (inb[PORT_A]),
      .q   (fwd_q[k])
    );
    exch_latch #(.W(W)) u_ret (
      .clk (clk),
      .le  (ret_le[k]),
      .d   (inb[k+1]),
      .q   (ret_q[k])
    );
  end

  always_comb begin
    drv_val[PORT_A] = (sel_e == RET_FROM_P1) ? ret_q[0] : ret_q[1];
    drv_val[PORT_1] = fwd_q[0];
    drv_val[PORT_2] = fwd_q[1];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pad
    exch_pad #(.W(W)) u_pad (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .drv_en  (drv_en[p]),
      .drv_val (drv_val[p]),
      .ext_en  (pin_ext[p]),
      .ext_val (pin_lvl[p]),
      .pad     (pad_lvl[p]),
      .inbound (inb[p])
    );
  end

  assign a_out  = drv_val[PORT_A];
  assign p1_out = drv_val[PORT_1];
  assign p2_out = drv_val[PORT_2];
  assign a_oe   = {W{drv_en[PORT_A]}};
  assign p1_oe  = {W{drv_en[PORT_1]}};
  assign p2_oe  = {W{drv_en[PORT_2]}};
  assign a_pad  = pad_lvl[PORT_A];
  assign p1_pad = pad_lvl[PORT_1];
  assign p2_pad = pad_lvl[PORT_2];
endmodule

// File: rtl/exch_checker.sv
module exch_checker #(
  parameter int unsigned W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fwd_le1,
  input logic         fwd_le2,
  input logic         ret_le1,
  input logic         ret_le2,
  input logic         ret_sel,
  input logic         a_oe_n,
  input logic         p1_oe_n,
  input logic         p2_oe_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_ext,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] a_pad,
  input logic [W-1:0] p1_in,
  input logic [W-1:0] p1_ext,
  input logic [W-1:0] p1_out,
  input logic [W-1:0] p1_oe,
  input logic [W-1:0] p1_pad,
  input logic [W-1:0] p2_in,
  input logic [W-1:0] p2_ext,
  input logic [W-1:0] p2_out,
  input logic [W-1:0] p2_oe,
  input logic [W-1:0] p2_pad
);
  a_r1_fwd_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_le1 && (&a_ext)) |-> (p1_out == a_in));

  a_r3_fwd2_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_le2 && (&a_ext)) |-> (p2_out == a_in));

  a_r2_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwd_le1 && $past(!fwd_le1)) |-> $stable(p1_out));

  a_r5_sel_p1: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_sel && ret_le1 && p1_oe_n && (&p1_ext)) |-> (a_out == p1_in));

  a_r4_sel_p2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_sel && ret_le2 && p2_oe_n && (&p2_ext)) |-> (a_out == p2_in));

  a_r6_pad_follows_out: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_oe_n) |-> (a_pad == a_out && (&a_oe)));

  a_r10_own_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!p2_oe_n && (&p2_ext)) |-> (p2_pad == p2_out));

  a_r8_keeper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_oe_n && p1_ext == '0 && $past(p1_oe_n) && $past(p1_ext == '0)) |-> $stable(p1_pad));

  a_r7_p_enables_indep: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_oe_n != p2_oe_n) |-> ((&p1_oe) != (&p2_oe)));
endmodule

bind tri_port_exchanger exch_checker #(.W(W)) u_exch_checker (
  .clk(clk), .rst_n(rst_n),
  .fwd_le1(fwd_le1), .fwd_le2(fwd_le2), .ret_le1(ret_le1), .ret_le2(ret_le2),
  .ret_sel(ret_sel), .a_oe_n(a_oe_n), .p1_oe_n(p1_oe_n), .p2_oe_n(p2_oe_n),
  .a_in(a_in), .a_ext(a_ext), .a_out(a_out), .a_oe(a_oe), .a_pad(a_pad),
  .p1_in(p1_in), .p1_ext(p1_ext), .p1_out(p1_out), .p1_oe(p1_oe), .p1_pad(p1_pad),
  .p2_in(p2_in), .p2_ext(p2_ext), .p2_out(p2_out), .p2_oe(p2_oe), .p2_pad(p2_pad)
);

// File: tb/tri_port_exchanger_bench.sv
module tri_port_exchanger_bench;
  localparam int W = 12;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n;
  logic fwd_le1, fwd_le2, ret_le1, ret_le2, ret_sel;
  logic a_oe_n, p1_oe_n, p2_oe_n;
  logic [W-1:0] a_in, a_ext, p1_in, p1_ext, p2_in, p2_ext;
  logic [W-1:0] a_out, a_oe, a_pad, p1_out, p1_oe, p1_pad, p2_out, p2_oe, p2_pad;

  always #5 clk = ~clk;

  tri_port_exchanger u_tri_port_exchanger (
    .clk(clk), .rst_n(rst_n),
    .fwd_le1(fwd_le1), .fwd_le2(fwd_le2), .ret_le1(ret_le1), .ret_le2(ret_le2),
    .ret_sel(ret_sel), .a_oe_n(a_oe_n), .p1_oe_n(p1_oe_n), .p2_oe_n(p2_oe_n),
    .a_in(a_in), .a_ext(a_ext), .a_out(a_out), .a_oe(a_oe), .a_pad(a_pad),
    .p1_in(p1_in), .p1_ext(p1_ext), .p1_out(p1_out), .p1_oe(p1_oe), .p1_pad(p1_pad),
    .p2_in(p2_in), .p2_ext(p2_ext), .p2_out(p2_out), .p2_oe(p2_oe), .p2_pad(p2_pad)
  );

  int n_chk = 0;
  int n_err = 0;
  bit ready = 0;
  bit done  = 0;

  // reference state: stored path values and kept pin levels
  logic [W-1:0] m_f1, m_f2, m_r1, m_r2;
  logic [W-1:0] k_a = '0, k_1 = '0, k_2 = '0;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] seen(input logic [W-1:0] ext, input logic [W-1:0] lvl,
                                        input logic [W-1:0] kept);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = ext[i] ? lvl[i] : kept[i];
    return r;
  endfunction

  function automatic logic [W-1:0] on_pin(input logic oe_n, input logic [W-1:0] drv,
                                          input logic [W-1:0] ext, input logic [W-1:0] lvl,
                                          input logic [W-1:0] kept);
    if (!oe_n) return drv;
    return seen(ext, lvl, kept);
  endfunction

  function automatic logic [W-1:0] e_p1();
    return fwd_le1 ? seen(a_ext, a_in, k_a) : m_f1;
  endfunction
  function automatic logic [W-1:0] e_p2();
    return fwd_le2 ? seen(a_ext, a_in, k_a) : m_f2;
  endfunction
  function automatic logic [W-1:0] e_a();
    logic [W-1:0] v1, v2;
    v1 = ret_le1 ? seen(p1_ext, p1_in, k_1) : m_r1;
    v2 = ret_le2 ? seen(p2_ext, p2_in, k_2) : m_r2;
    return ret_sel ? v1 : v2;
  endfunction

  task automatic settle();
    #1;
    if (ready) begin
      chk("R5 a_out", a_out, e_a());
      chk("R1/R2/R3 p1_out", p1_out, e_p1());
      chk("R1/R2/R3 p2_out", p2_out, e_p2());
      chk("R6 a_oe", a_oe, a_oe_n ? '0 : ONES);
      chk("R6/R7 p1_oe", p1_oe, p1_oe_n ? '0 : ONES);
      chk("R6/R7 p2_oe", p2_oe, p2_oe_n ? '0 : ONES);
      chk("R8/R10 a_pad", a_pad, on_pin(a_oe_n, e_a(), a_ext, a_in, k_a));
      chk("R8/R10 p1_pad", p1_pad, on_pin(p1_oe_n, e_p1(), p1_ext, p1_in, k_1));
      chk("R8/R10 p2_pad", p2_pad, on_pin(p2_oe_n, e_p2(), p2_ext, p2_in, k_2));
    end
  endtask

  task automatic tick();
    logic [W-1:0] pa, p1, p2, ia, i1, i2;
    @(posedge clk);
    pa = on_pin(a_oe_n, e_a(), a_ext, a_in, k_a);
    p1 = on_pin(p1_oe_n, e_p1(), p1_ext, p1_in, k_1);
    p2 = on_pin(p2_oe_n, e_p2(), p2_ext, p2_in, k_2);
    ia = seen(a_ext, a_in, k_a);
    i1 = seen(p1_ext, p1_in, k_1);
    i2 = seen(p2_ext, p2_in, k_2);
    if (fwd_le1) m_f1 = ia;
    if (fwd_le2) m_f2 = ia;
    if (ret_le1) m_r1 = i1;
    if (ret_le2) m_r2 = i2;
    for (int i = 0; i < W; i++) begin
      if (!a_oe_n  || a_ext[i])  k_a[i] = pa[i];
      if (!p1_oe_n || p1_ext[i]) k_1[i] = p1[i];
      if (!p2_oe_n || p2_ext[i]) k_2[i] = p2[i];
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    {fwd_le1, fwd_le2, ret_le1, ret_le2, ret_sel} = '0;
    {a_oe_n, p1_oe_n, p2_oe_n} = 3'b111;
    a_in = '0; p1_in = '0; p2_in = '0;
    a_ext = '0; p1_ext = '0; p2_ext = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R9: keepers cleared, nothing driven
    chk("R9 a_pad", a_pad, '0);
    chk("R9 p1_pad", p1_pad, '0);
    chk("R9 p2_pad", p2_pad, '0);
    chk("R9 a_oe", a_oe, '0);
    chk("R9 p1_oe", p1_oe, '0);
    chk("R9 p2_oe", p2_oe, '0);
    @(negedge clk);

    // open every latch with known data
    a_ext = ONES; p1_ext = ONES; p2_ext = ONES;
    {fwd_le1, fwd_le2, ret_le1, ret_le2} = 4'b1111;
    tick();
    ready = 1;

    // R1, R3: one A value reaches both forward paths
    a_in = 12'hABC;
    settle();
    chk("R1 p1_out transparent", p1_out, 12'hABC);
    chk("R3 p2_out shares A", p2_out, 12'hABC);
    tick();

    // R2: close path 1 only, then change A
    fwd_le1 = 1'b0;
    a_in = 12'h123;
    settle();
    chk("R2 p1_out held", p1_out, 12'hABC);
    chk("R1 p2_out follows", p2_out, 12'h123);
    tick();
    a_in = 12'hF0F;
    settle();
    chk("R2 p1_out held after edge", p1_out, 12'hABC);
    fwd_le2 = 1'b0;
    tick();

    // R4, R5: capture both return paths then select
    p1_in = 12'h5A5; p2_in = 12'h3C3;
    ret_le1 = 1'b1; ret_le2 = 1'b1;
    tick();
    ret_le1 = 1'b0; ret_le2 = 1'b0;
    p1_in = 12'h000; p2_in = 12'h000;
    ret_sel = 1'b1;
    settle();
    chk("R4 a_out from P1 hold", a_out, 12'h5A5);
    ret_sel = 1'b0;
    settle();
    chk("R5 a_out from P2 hold", a_out, 12'h3C3);

    // R6, R10: A drives over an external driver
    a_oe_n = 1'b0;
    a_in = 12'hFFF;
    settle();
    chk("R6 a_oe all ones", a_oe, ONES);
    chk("R10 a_pad own value", a_pad, 12'h3C3);
    tick();
    a_oe_n = 1'b1;

    // R7: P1 drives stored data while P2 passes through to A
    p1_oe_n = 1'b0; p2_oe_n = 1'b1;
    p2_in = 12'h777; ret_le2 = 1'b1; ret_sel = 1'b0;
    settle();
    chk("R7 a_out from P2 live", a_out, 12'h777);
    chk("R7 p1_pad driven", p1_pad, 12'hABC);
    chk("R7 p1_oe", p1_oe, ONES);
    chk("R7 p2_oe", p2_oe, '0);
    tick();

    // R8: release P2 entirely, level is kept
    ret_le2 = 1'b0; p2_ext = '0; p2_in = 12'h000;
    settle();
    chk("R8 p2_pad kept", p2_pad, 12'h777);
    tick(); tick(); tick();
    settle();
    chk("R8 p2_pad kept over edges", p2_pad, 12'h777);
    ret_le2 = 1'b1;
    settle();
    chk("R8 inbound from keeper", a_out, 12'h777);
    tick();
    p1_oe_n = 1'b1;
    tick();

    // randomised cycles against the reference
    for (int c = 0; c < 400; c++) begin
      {fwd_le1, fwd_le2, ret_le1, ret_le2, ret_sel} = 5'($urandom);
      {a_oe_n, p1_oe_n, p2_oe_n} = 3'($urandom) | 3'($urandom);
      a_in = W'($urandom); p1_in = W'($urandom); p2_in = W'($urandom);
      a_ext = W'($urandom); p1_ext = W'($urandom); p2_ext = W'($urandom);
      settle();
      tick();
    end

    done = 1;
    finish_run();
  end
endmodule